// File: doc/BRIEF.md
# Bridge Memory Window Address Decoder

This block sits on the host side of a bridge and sorts every memory request address into one of three destinations. The first is a 256 MB configuration-space block placed on any 256 MB boundary below 4 GB. The second is a non-prefetchable memory window that is forwarded to the downstream link. The third is a prefetchable memory window that is also forwarded downstream and carries a write-combining attribute. An address that falls in none of these is not claimed. Each window is an inclusive base/limit pair. A single memory-enable control bit gates both windows.

Software or a boot agent loads the window bounds, the configuration base and the enable bit through a simple register write port. A request comes in as an address and a valid strobe. One clock later the decoder presents a registered result: a valid flag, the address unchanged, at most one hit flag, the write-combining flag, and, for configuration hits, the address offset split into bus, device, function and register fields.

Top module: `mwd_bridge_decoder`

## Requirements
- R1: When the enable bit is set and base ≤ address ≤ limit for the non-prefetchable window (write select 1 = base, 2 = limit), `hit_np` is asserted. Both bounds are inclusive.
- R2: When the enable bit is set and base ≤ address ≤ limit for the prefetchable window (write select 3 = base, 4 = limit), `hit_pf` is asserted. Both bounds are inclusive, and this window is independent of the non-prefetchable one.
- R3: `wc_attr` is asserted together with `hit_pf` and is never asserted for any other kind of result.
- R4: The memory enable is bit 0 written at select 0. While it is clear, neither window claims any address.
- R5: The configuration base register (select 5) keeps only write-data bits [31:28], and the other bits of that write are ignored. An address whose bits [31:28] equal the stored value hits the 256 MB configuration block, whether the enable bit is set or not.
- R6: On a configuration hit, `cfg_bus` = address[27:20], `cfg_dev` = address[19:15], `cfg_fn` = address[14:12] and `cfg_reg` = address[11:0]. These fields are zero on any other result.
- R7: Priority runs configuration block, then non-prefetchable window, then prefetchable window. At most one hit flag is ever asserted.
- R8: A window whose limit is below its base claims no address.
- R9: The results appear on the clock edge after a request is sampled. `rsp_valid` follows `req_valid` by one cycle, and `rsp_addr` equals the request address unchanged. A cycle without a request produces `rsp_valid` low and no hits.
- R10: After a synchronous active-low reset, all registers are zero and the enable bit is clear. So the configuration block sits at address 0, and neither window claims anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (0 enable, 1/2 non-prefetchable base/limit, 3/4 prefetchable base/limit, 5 configuration base) |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Request address strobe |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Result valid, one cycle after the request |
| rsp_addr | output | 32 | Request address passed through unchanged |
| hit_cfg | output | 1 | Configuration block hit |
| hit_np | output | 1 | Non-prefetchable window hit |
| hit_pf | output | 1 | Prefetchable window hit |
| wc_attr | output | 1 | Write-combining attribute |
| cfg_bus | output | 8 | Configuration offset bus field |
| cfg_dev | output | 5 | Configuration offset device field |
| cfg_fn | output | 3 | Configuration offset function field |
| cfg_reg | output | 12 | Configuration offset register field |

## Verification
A corrupted bound or enable register shows up on the very next request that lands near the affected edge. The requests at exactly base, at exactly limit, and one address outside each edge are there to expose an off-by-one or a lost enable within a single cycle. A broken priority path shows up as either two hit flags or the wrong single flag on an address where two regions overlap. A stuck attribute shows up as `wc_attr` disagreeing with `hit_pf` on the same response.

// File: rtl/mwd_pkg.sv
// Package: shared constants for the bridge memory window decoder.
// Assumes a fixed configuration-offset layout of bus/device/function/register.
package mwd_pkg;
    localparam int SEL_W   = 3;
    localparam int NUM_WIN = 2;            // index 0 non-prefetchable, 1 prefetchable
    localparam int REG_W   = 12;
    localparam int FN_W    = 3;
    localparam int DEV_W   = 5;
    localparam int OFFS_LO = REG_W + FN_W + DEV_W;   // first bus bit

    localparam logic [SEL_W-1:0] SEL_CTRL     = 3'd0;
    localparam logic [SEL_W-1:0] SEL_CFG_BASE = 3'd5;

    // Base select for window i is 1+2i, limit select is 2+2i.
    function automatic logic [SEL_W-1:0] win_base_sel(input int idx);
        return SEL_W'(1 + 2 * idx);
    endfunction

    function automatic logic [SEL_W-1:0] win_lim_sel(input int idx);
        return SEL_W'(2 + 2 * idx);
    endfunction
endpackage

// File: rtl/mwd_regs.sv
// Module: holds the decoder's programmable state (enable, window bounds,
// configuration base upper bits). Assumes one write per cycle; unknown
// selects are dropped. Synchronous active-low reset clears everything.
module mwd_regs #(
    parameter int ADDR_W        = 32,
    parameter int CFG_SPAN_LOG2 = 28
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      we,
    input  logic [mwd_pkg::SEL_W-1:0]                 sel,
    input  logic [ADDR_W-1:0]                         wdata,
    output logic                                      mem_en,
    output logic [mwd_pkg::NUM_WIN-1:0][ADDR_W-1:0]   win_base,
    output logic [mwd_pkg::NUM_WIN-1:0][ADDR_W-1:0]   win_lim,
    output logic [ADDR_W-CFG_SPAN_LOG2-1:0]           cfg_hi
);
    import mwd_pkg::*;

    localparam int HI_W = ADDR_W - CFG_SPAN_LOG2;

    // Enable bit and configuration base upper bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_en <= 1'b0;
            cfg_hi <= '0;
        end else if (we) begin
            if (sel == SEL_CTRL)     mem_en <= wdata[0];
            if (sel == SEL_CFG_BASE) cfg_hi <= wdata[ADDR_W-1:CFG_SPAN_LOG2];
        end
    end

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
        logic [ADDR_W-1:0] base_q;
        logic [ADDR_W-1:0] lim_q;

        // Per-window base and limit storage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                base_q <= '0;
                lim_q  <= '0;
            end else if (we) begin
                if (sel == win_base_sel(gi)) base_q <= wdata;
                if (sel == win_lim_sel(gi))  lim_q  <= wdata;
            end
        end

        assign win_base[gi] = base_q;
        assign win_lim[gi]  = lim_q;
    end

    logic unused_hi;
    assign unused_hi = ^HI_W;
endmodule

// File: rtl/mwd_range_cmp.sv
// Module: inclusive base/limit window match. Assumes unsigned bounds;
// an inverted window (limit below base) matches nothing by arithmetic.
module mwd_range_cmp #(
    parameter int ADDR_W = 32
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] lim,
    output logic              hit
);
    // Both bounds inclusive, gated by the enable.
    always_comb hit = en && (addr >= base) && (addr <= lim);
endmodule

// File: rtl/mwd_cfg_match.sv
// Module: configuration block match and offset split. Assumes the block
// is 2**CFG_SPAN_LOG2 bytes, aligned, and selected by the upper address bits.
module mwd_cfg_match #(
    parameter int ADDR_W        = 32,
    parameter int CFG_SPAN_LOG2 = 28
) (
    input  logic [ADDR_W-1:0]                          addr,
    input  logic [ADDR_W-CFG_SPAN_LOG2-1:0]            cfg_hi,
    output logic                                       hit,
    output logic [CFG_SPAN_LOG2-mwd_pkg::OFFS_LO-1:0]  bus,
    output logic [mwd_pkg::DEV_W-1:0]                  dev,
    output logic [mwd_pkg::FN_W-1:0]                   fn,
    output logic [mwd_pkg::REG_W-1:0]                  regno
);
    import mwd_pkg::*;

    // Compare upper bits and slice the offset into its fields.
    always_comb begin
        hit   = (addr[ADDR_W-1:CFG_SPAN_LOG2] == cfg_hi);
        bus   = addr[CFG_SPAN_LOG2-1:OFFS_LO];
        dev   = addr[OFFS_LO-1:REG_W+FN_W];
        fn    = addr[REG_W+FN_W-1:REG_W];
        regno = addr[REG_W-1:0];
    end
endmodule

// File: rtl/mwd_bridge_decoder.sv
// Module: top of the bridge memory window decoder. Classifies each request
// address as configuration, non-prefetchable or prefetchable hit, with fixed
// priority, and registers the result one cycle after the request strobe.
// Assumes register writes and requests in the same cycle see the old values.
module mwd_bridge_decoder #(
    parameter int ADDR_W        = 32,
    parameter int CFG_SPAN_LOG2 = 28
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      cfg_we,
    input  logic [2:0]                                cfg_sel,
    input  logic [ADDR_W-1:0]                         cfg_wdata,
    input  logic                                      req_valid,
    input  logic [ADDR_W-1:0]                         req_addr,
    output logic                                      rsp_valid,
    output logic [ADDR_W-1:0]                         rsp_addr,
    output logic                                      hit_cfg,
    output logic                                      hit_np,
    output logic                                      hit_pf,
    output logic                                      wc_attr,
    output logic [CFG_SPAN_LOG2-21:0]                 cfg_bus,
    output logic [4:0]                                cfg_dev,
    output logic [2:0]                                cfg_fn,
    output logic [11:0]                               cfg_reg
);
    import mwd_pkg::*;

    localparam int HI_W  = ADDR_W - CFG_SPAN_LOG2;
    localparam int BUS_W = CFG_SPAN_LOG2 - OFFS_LO;

    logic                               mem_en_q;
    logic [NUM_WIN-1:0][ADDR_W-1:0]     win_base;
    logic [NUM_WIN-1:0][ADDR_W-1:0]     win_lim;
    logic [HI_W-1:0]                    cfg_hi_q;
    logic [NUM_WIN-1:0]                 win_hit;
    logic                               cfg_hit;
    logic [BUS_W-1:0]                   off_bus;
    logic [DEV_W-1:0]                   off_dev;
    logic [FN_W-1:0]                    off_fn;
    logic [REG_W-1:0]                   off_reg;
    logic                               sel_cfg, sel_np, sel_pf;

    mwd_regs #(.ADDR_W(ADDR_W), .CFG_SPAN_LOG2(CFG_SPAN_LOG2)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .sel      (cfg_sel),
        .wdata    (cfg_wdata),
        .mem_en   (mem_en_q),
        .win_base (win_base),
        .win_lim  (win_lim),
        .cfg_hi   (cfg_hi_q)
    );

    for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_cmp
        mwd_range_cmp #(.ADDR_W(ADDR_W)) u_cmp (
            .en   (mem_en_q),
            .addr (req_addr),
            .base (win_base[gi]),
            .lim  (win_lim[gi]),
            .hit  (win_hit[gi])
        );
    end

    mwd_cfg_match #(.ADDR_W(ADDR_W), .CFG_SPAN_LOG2(CFG_SPAN_LOG2)) u_cfg (
        .addr   (req_addr),
        .cfg_hi (cfg_hi_q),
        .hit    (cfg_hit),
        .bus    (off_bus),
        .dev    (off_dev),
        .fn     (off_fn),
        .regno  (off_reg)
    );

    // Fixed priority: configuration, then non-prefetchable, then prefetchable.
    always_comb begin
        sel_cfg = cfg_hit;
        sel_np  = win_hit[0] && !cfg_hit;
        sel_pf  = win_hit[1] && !cfg_hit && !win_hit[0];
    end

    // Result register, cleared on idle cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid <= 1'b0;
            rsp_addr  <= '0;
            hit_cfg   <= 1'b0;
            hit_np    <= 1'b0;
            hit_pf    <= 1'b0;
            wc_attr   <= 1'b0;
            cfg_bus   <= '0;
            cfg_dev   <= '0;
            cfg_fn    <= '0;
            cfg_reg   <= '0;
        end else begin
            rsp_valid <= 1'b1;
            rsp_addr  <= req_addr;
            hit_cfg   <= sel_cfg;
            hit_np    <= sel_np;
            hit_pf    <= sel_pf;
            wc_attr   <= sel_pf;
            cfg_bus   <= sel_cfg ? off_bus : '0;
            cfg_dev   <= sel_cfg ? off_dev : '0;
            cfg_fn    <= sel_cfg ? off_fn  : '0;
            cfg_reg   <= sel_cfg ? off_reg : '0;
        end
    end
endmodule

// File: rtl/mwd_bridge_decoder_chk.sv
// Module: property checker for the bridge decoder, bound to every instance.
// Assumes the internal register names of the top module.
module mwd_bridge_decoder_chk #(
    parameter int ADDR_W        = 32,
    parameter int CFG_SPAN_LOG2 = 28
) (
    input logic                                   clk,
    input logic                                   rst_n,
    input logic                                   req_valid,
    input logic [ADDR_W-1:0]                      req_addr,
    input logic                                   rsp_valid,
    input logic [ADDR_W-1:0]                      rsp_addr,
    input logic                                   hit_cfg,
    input logic                                   hit_np,
    input logic                                   hit_pf,
    input logic                                   wc_attr,
    input logic [CFG_SPAN_LOG2-21:0]              cfg_bus,
    input logic                                   mem_en_q,
    input logic [ADDR_W-CFG_SPAN_LOG2-1:0]        cfg_hi_q,
    input logic [1:0][ADDR_W-1:0]                 win_base,
    input logic [1:0][ADDR_W-1:0]                 win_lim
);
    assert_one_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit_cfg, hit_np, hit_pf}));

    assert_wc_only_pf_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wc_attr |-> hit_pf);

    assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

    assert_passthru_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_addr == $past(req_addr)));

    assert_hit_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_cfg || hit_np || hit_pf) |-> rsp_valid);

    assert_enable_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_np || hit_pf) |-> $past(mem_en_q));

    assert_np_bounds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_np |-> ($past(req_addr) >= $past(win_base[0]) &&
                    $past(req_addr) <= $past(win_lim[0])));

    assert_pf_bounds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_pf |-> ($past(req_addr) >= $past(win_base[1]) &&
                    $past(req_addr) <= $past(win_lim[1])));

    assert_cfg_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg |-> ($past(req_addr[ADDR_W-1:CFG_SPAN_LOG2]) == $past(cfg_hi_q)));

    assert_cfg_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cfg |-> (cfg_bus == $past(req_addr[CFG_SPAN_LOG2-1:20])));
endmodule

bind mwd_bridge_decoder mwd_bridge_decoder_chk #(
    .ADDR_W(ADDR_W), .CFG_SPAN_LOG2(CFG_SPAN_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_addr  (rsp_addr),
    .hit_cfg   (hit_cfg),
    .hit_np    (hit_np),
    .hit_pf    (hit_pf),
    .wc_attr   (wc_attr),
    .cfg_bus   (cfg_bus),
    .mem_en_q  (mem_en_q),
    .cfg_hi_q  (cfg_hi_q),
    .win_base  (win_base),
    .win_lim   (win_lim)
);

// File: tb/mwd_bridge_decoder_bench.sv
// Bench: vector table walk plus directed reset and corner-case tests.
module mwd_bridge_decoder_bench;
    localparam int CLK_PERIOD = 10;

    // kind: 0 none, 1 configuration, 2 non-prefetchable, 3 prefetchable
    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  kind;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{32'h7FFF_FFFF, 2'd0},
        '{32'h8000_0000, 2'd2},
        '{32'h8800_0000, 2'd2},
        '{32'h8FFF_FFFF, 2'd2},
        '{32'h9000_0000, 2'd3},
        '{32'h9FFF_FFFF, 2'd3},
        '{32'hA000_0000, 2'd0},
        '{32'hDFFF_FFFF, 2'd0},
        '{32'hE000_0000, 2'd1},
        '{32'hE5AC_9ABC, 2'd1},
        '{32'hEFFF_FFFF, 2'd1},
        '{32'hF000_0000, 2'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        hit_cfg, hit_np, hit_pf, wc_attr;
    logic [7:0]  cfg_bus;
    logic [4:0]  cfg_dev;
    logic [2:0]  cfg_fn;
    logic [11:0] cfg_reg;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    mwd_bridge_decoder u_mwd_bridge_decoder (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .hit_cfg(hit_cfg),
        .hit_np(hit_np), .hit_pf(hit_pf), .wc_attr(wc_attr),
        .cfg_bus(cfg_bus), .cfg_dev(cfg_dev), .cfg_fn(cfg_fn), .cfg_reg(cfg_reg)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One request; outputs sampled at the following negedge.
    task automatic req(input logic [31:0] a);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_kind(input string tag, input logic [31:0] a, input logic [1:0] kind);
        chk({tag, " R9 valid"}, 32'(rsp_valid), 32'd1);
        chk({tag, " R9 addr"}, rsp_addr, a);
        chk({tag, " R7 hits"}, {29'd0, hit_cfg, hit_np, hit_pf},
            {29'd0, kind == 2'd1, kind == 2'd2, kind == 2'd3});
        chk({tag, " R3 wc"}, 32'(wc_attr), 32'(kind == 2'd3));
        chk({tag, " R6 fields"}, {cfg_bus, cfg_dev, cfg_fn, cfg_reg},
            (kind == 2'd1) ? {4'd0, a[27:0]} : 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state at the ports
        chk("R10 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R10 hits", {29'd0, hit_cfg, hit_np, hit_pf}, 32'd0);

        // R10 and R5: config base zero after reset, decoded without enable
        req(32'h0000_1000);
        expect_kind("R10 cfg at zero", 32'h0000_1000, 2'd1);

        // R4 and R10: windows cleared and disabled, claim nothing
        req(32'h4000_0000);
        expect_kind("R4 reset disabled", 32'h4000_0000, 2'd0);

        // Program windows; R5: low bits of the config base write are dropped
        wr(3'd1, 32'h8000_0000);
        wr(3'd2, 32'h8FFF_FFFF);
        wr(3'd3, 32'h8800_0000);
        wr(3'd4, 32'h9FFF_FFFF);
        wr(3'd5, 32'hE123_4567);

        // R4: windows still disabled
        req(32'h8000_0000);
        expect_kind("R4 disabled np", 32'h8000_0000, 2'd0);
        req(32'h9000_0000);
        expect_kind("R4 disabled pf", 32'h9000_0000, 2'd0);

        wr(3'd0, 32'd1);

        // R1 R2 R3 R5 R6 R7: table walk
        for (int i = 0; i < NVEC; i++) begin
            req(VECS[i].addr);
            expect_kind($sformatf("R1 R2 R5 vec%0d", i), VECS[i].addr, VECS[i].kind);
        end

        // R9: an idle cycle gives no valid and no hits
        @(negedge clk);
        chk("R9 idle valid", 32'(rsp_valid), 32'd0);
        chk("R9 idle hits", {29'd0, hit_cfg, hit_np, hit_pf}, 32'd0);

        // R7: configuration block wins over an overlapping window
        wr(3'd1, 32'hD000_0000);
        wr(3'd2, 32'hFFFF_FFFF);
        req(32'hE000_0010);
        expect_kind("R7 cfg over np", 32'hE000_0010, 2'd1);
        req(32'hF000_0000);
        expect_kind("R7 np above cfg", 32'hF000_0000, 2'd2);

        // R8: inverted window claims nothing, even at its own bounds
        wr(3'd1, 32'hC000_0000);
        wr(3'd2, 32'hB000_0000);
        req(32'hB800_0000);
        expect_kind("R8 inverted mid", 32'hB800_0000, 2'd0);
        req(32'hC000_0000);
        expect_kind("R8 inverted base", 32'hC000_0000, 2'd0);

        // R4: clearing enable stops the prefetchable window again
        wr(3'd0, 32'd0);
        req(32'h9000_0000);
        expect_kind("R4 cleared", 32'h9000_0000, 2'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule